// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Control

This block decides, for each source operand of the instruction sitting in decode of a five-stage in-order pipeline, where that operand's value must come from. It compares both source register numbers against the destination registers of the instructions now in the execute, memory and writeback stages. Only stages whose register-write enable is set take part. A match selects a bypass path, and the closest producer wins. When the producer in execute is a load, its data does not exist yet, so the block asks the pipeline to hold decode for one cycle instead.

The decisions are registered. The pipeline drives the inputs with the values its stage registers are about to take, and the selects and the stall appear one cycle later, aligned with the instruction that uses them. Register 0 is hard-wired to zero and never counts as a dependence. The parameter `WB_BYPASS` removes the writeback bypass. Set it to 0 when the register file writes in the first half of the cycle and reads in the second.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While `rst_n` is low, `fwd_a` and `fwd_b` read 00 (register file) and `stall` reads 0.
- R2: A source register number of 0 never matches any stage: its select is 00 and it never causes a stall.
- R3: A source matching the execute-stage destination, with `ex_we`=1 and `ex_ld`=0, gets select 01.
- R4: A source matching the memory-stage destination with `mem_we`=1, and not matching execute, gets select 10. This holds whether or not the memory-stage instruction is a load.
- R5: With `WB_BYPASS`=1, a source that matches only the writeback-stage destination with `wb_we`=1 gets select 11.
- R6: With `WB_BYPASS`=0, select 11 is never produced, and a writeback-only match gets 00.
- R7: When several stages match, execute wins over memory and memory wins over writeback.
- R8: `stall` is 1 when either source matches the execute-stage destination with `ex_we`=1 and `ex_ld`=1.
- R9: `stall` is 0 in every other case, including a load match in the memory or writeback stage and a load in execute that writes another register.
- R10: A stage with its write enable at 0 never matches, even when its destination equals a source.
- R11: Outputs change one clock edge after the inputs are applied. Before that edge they keep the previous decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | REG_W | First source register of the decode instruction |
| src_b | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage register write enable |
| ex_ld | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | REG_W | Writeback-stage destination register |
| wb_we | input | 1 | Writeback-stage register write enable |
| fwd_a | output | 2 | Source for operand A: 00 file, 01 EX, 10 MEM, 11 WB |
| fwd_b | output | 2 | Source for operand B, same encoding |
| stall | output | 1 | Hold decode for one cycle (load-use) |

## Verification
The bench builds two copies that share every input: one with `WB_BYPASS`=1 and one with `WB_BYPASS`=0, both with `REG_W`=5. The first copy exposes the full three-level priority and the writeback bypass. The second shows that a writeback-only match falls back to the register file and that select 11 never appears. Driving both with the same pattern makes the difference between the two modes visible in a single cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_EX  = 2'b01,
        SRC_MEM = 2'b10,
        SRC_WB  = 2'b11
    } fwd_src_e;
endpackage

// File: rtl/hzd_fwd_lane.sv
module hzd_fwd_lane
    import hzd_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit WB_BYPASS = 1'b1
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_ld,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output fwd_src_e         sel,
    output logic             ld_hit
);
    logic src_live;
    logic ex_hit;
    logic mem_hit;
    logic wb_hit;

    assign src_live = (src != '0);
    assign ex_hit   = src_live && ex_we  && (ex_rd  == src);
    assign mem_hit  = src_live && mem_we && (mem_rd == src);

    generate
        if (WB_BYPASS) begin : g_wb_path
            assign wb_hit = src_live && wb_we && (wb_rd == src);
        end else begin : g_wb_none
            logic unused_wb;
            assign unused_wb = ^{wb_rd, wb_we};
            assign wb_hit    = 1'b0;
        end
    endgenerate

    always_comb begin
        sel = SRC_RF;
        if (ex_hit) begin
            sel = ex_ld ? SRC_RF : SRC_EX;
        end else if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end
    end

    assign ld_hit = ex_hit && ex_ld;
endmodule

// File: rtl/hzd_stall_merge.sv
module hzd_stall_merge #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] hits,
    output logic               any_hit
);
    assign any_hit = |hits;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit WB_BYPASS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_ld,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             stall
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]   src_vec [NUM_SRC];
    fwd_src_e           sel_d   [NUM_SRC];
    fwd_src_e           sel_q   [NUM_SRC];
    logic [NUM_SRC-1:0] ld_hits;
    logic               stall_d;
    logic               stall_q;

    assign src_vec[0] = src_a;
    assign src_vec[1] = src_b;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
            hzd_fwd_lane #(
                .REG_W     (REG_W),
                .WB_BYPASS (WB_BYPASS)
            ) u_lane (
                .src    (src_vec[i]),
                .ex_rd  (ex_rd),
                .ex_we  (ex_we),
                .ex_ld  (ex_ld),
                .mem_rd (mem_rd),
                .mem_we (mem_we),
                .wb_rd  (wb_rd),
                .wb_we  (wb_we),
                .sel    (sel_d[i]),
                .ld_hit (ld_hits[i])
            );
        end
    endgenerate

    hzd_stall_merge #(
        .NUM_SRC (NUM_SRC)
    ) u_merge (
        .hits    (ld_hits),
        .any_hit (stall_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                sel_q[i] <= SRC_RF;
            end
            stall_q <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                sel_q[i] <= sel_d[i];
            end
            stall_q <= stall_d;
        end
    end

    always_comb begin
        fwd_a = sel_q[0];
        fwd_b = sel_q[1];
        stall = stall_q;
    end
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int REG_W     = 5,
    parameter bit WB_BYPASS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] src_a,
    input logic [REG_W-1:0] src_b,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_we,
    input logic             ex_ld,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_we,
    input logic             wb_we,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             stall
);
    logic ld_dep;
    assign ld_dep = ex_we && ex_ld &&
                    (((src_a != '0) && (ex_rd == src_a)) ||
                     ((src_b != '0) && (ex_rd == src_b)));

    a_r2_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a == '0) |=> (fwd_a == 2'b00));

    a_r3_ex_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_a != '0) && ex_we && !ex_ld && (ex_rd == src_a)) |=> (fwd_a == 2'b01));

    a_r4_mem_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_b != '0) && mem_we && (mem_rd == src_b) && !(ex_we && (ex_rd == src_b)))
        |=> (fwd_b == 2'b10));

    a_r8_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dep |=> stall);

    a_r9_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_dep |=> !stall);

    a_r10_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we && !wb_we) |=> ((fwd_a == 2'b00) && (fwd_b == 2'b00) && !stall));

    generate
        if (!WB_BYPASS) begin : g_split
            a_r6_no_wb_sel: assert property (@(posedge clk) disable iff (!rst_n)
                (fwd_a != 2'b11) && (fwd_b != 2'b11));
        end
    endgenerate
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(
    .REG_W     (REG_W),
    .WB_BYPASS (WB_BYPASS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_a  (src_a),
    .src_b  (src_b),
    .ex_rd  (ex_rd),
    .ex_we  (ex_we),
    .ex_ld  (ex_ld),
    .mem_rd (mem_rd),
    .mem_we (mem_we),
    .wb_we  (wb_we),
    .fwd_a  (fwd_a),
    .fwd_b  (fwd_b),
    .stall  (stall)
);

// File: tb/hazard_fwd_unit_bench.sv
`timescale 1ns/1ps
module hazard_fwd_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_a = '0, src_b = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic       ex_we = 1'b0, ex_ld = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [1:0] fwd_a, fwd_b, sp_a, sp_b;
    logic       stall, sp_stall;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    hazard_fwd_unit #(.REG_W(5), .WB_BYPASS(1'b1)) u_hazard_fwd_unit (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall));

    hazard_fwd_unit #(.REG_W(5), .WB_BYPASS(1'b0)) u_hazard_fwd_unit_split (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a(sp_a), .fwd_b(sp_b), .stall(sp_stall));

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] exr, input logic exw, input logic exl,
                         input logic [4:0] mr, input logic mw,
                         input logic [4:0] wr, input logic ww);
        @(negedge clk);
        src_a = a; src_b = b; ex_rd = exr; ex_we = exw; ex_ld = exl;
        mem_rd = mr; mem_we = mw; wb_rd = wr; wb_we = ww;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "fwd_a in reset", fwd_a, 0);
        chk("R1", "fwd_b in reset", fwd_b, 0);
        chk("R1", "stall in reset", stall, 0);
    endtask

    task automatic t_ex_bypass;
        drive(5'd3, 5'd4, 5'd3, 1, 0, 5'd9, 1, 5'd10, 1);
        chk("R3", "fwd_a ex match", fwd_a, 1);
        chk("R3", "fwd_b no match", fwd_b, 0);
        chk("R9", "stall alu producer", stall, 0);
    endtask

    task automatic t_mem_bypass;
        drive(5'd2, 5'd7, 5'd1, 1, 0, 5'd7, 1, 5'd0, 0);
        chk("R4", "fwd_b mem match", fwd_b, 2);
        chk("R4", "fwd_a no match", fwd_a, 0);
    endtask

    task automatic t_wb_modes;
        drive(5'd9, 5'd11, 5'd1, 1, 0, 5'd2, 1, 5'd9, 1);
        chk("R5", "fwd_a wb match bypass on", fwd_a, 3);
        chk("R6", "fwd_a wb match split mode", sp_a, 0);
        chk("R6", "fwd_b split mode", sp_b, 0);
    endtask

    task automatic t_priority;
        drive(5'd5, 5'd6, 5'd5, 1, 0, 5'd5, 1, 5'd5, 1);
        chk("R7", "fwd_a ex beats mem and wb", fwd_a, 1);
        drive(5'd5, 5'd6, 5'd1, 1, 0, 5'd6, 1, 5'd6, 1);
        chk("R7", "fwd_b mem beats wb", fwd_b, 2);
        chk("R7", "fwd_b mem beats wb split", sp_b, 2);
    endtask

    task automatic t_zero_reg;
        drive(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 5'd0, 1);
        chk("R2", "fwd_a src zero", fwd_a, 0);
        chk("R2", "fwd_b src zero", fwd_b, 0);
        chk("R2", "stall src zero load", stall, 0);
    endtask

    task automatic t_we_low;
        drive(5'd12, 5'd13, 5'd12, 0, 0, 5'd13, 0, 5'd12, 0);
        chk("R10", "fwd_a we low", fwd_a, 0);
        chk("R10", "fwd_b we low", fwd_b, 0);
        chk("R10", "stall we low", stall, 0);
    endtask

    task automatic t_load_use;
        drive(5'd1, 5'd8, 5'd8, 1, 1, 5'd3, 1, 5'd4, 1);
        chk("R8", "stall load in ex operand b", stall, 1);
        chk("R8", "stall split operand b", sp_stall, 1);
        drive(5'd8, 5'd2, 5'd8, 1, 1, 5'd3, 1, 5'd4, 1);
        chk("R8", "stall load in ex operand a", stall, 1);
    endtask

    task automatic t_load_elsewhere;
        drive(5'd1, 5'd8, 5'd3, 1, 0, 5'd8, 1, 5'd4, 1);
        chk("R9", "stall load now in mem", stall, 0);
        chk("R4", "fwd_b load data from mem", fwd_b, 2);
        drive(5'd1, 5'd8, 5'd20, 1, 1, 5'd3, 1, 5'd4, 1);
        chk("R9", "stall load other reg", stall, 0);
    endtask

    task automatic t_latency;
        drive(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 5'd0, 0);
        @(negedge clk);
        src_a = 5'd14; ex_rd = 5'd14; ex_we = 1'b1; ex_ld = 1'b0;
        #1;
        chk("R11", "fwd_a before edge", fwd_a, 0);
        @(posedge clk);
        #1;
        chk("R11", "fwd_a after edge", fwd_a, 1);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_ex_bypass();
        t_mem_bypass();
        t_wb_modes();
        t_priority();
        t_zero_reg();
        t_we_low();
        t_load_use();
        t_load_elsewhere();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule